// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block is the transmit half of an asynchronous serial port. A one-byte holding register sits in front of a frame shifter, so software can hand over the next character while the current one is still on the wire. A character written into the holding register waits there until the shifter can take it. The shifter then drives the character out as a start bit, seven or eight data bits, an optional parity bit and one or two stop bits. Each bit lasts one period of an external bit-rate tick.

Two status flags tell software what is happening. One reports that a character is waiting in the holding register. The other reports that a frame is on the wire. A one-cycle interrupt pulse marks the end of each completed frame. Transmission runs only while both the master clock enable and the transmit enable are set. Dropping either enable flushes the holding register and cuts off any frame in flight, and the line returns to idle.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset, `tx_line` is 1, `tx_status` is 2'b00 and `tx_irq` is 0.
- R2: A write (`wr_en` high) while both enables are set and `tx_status[1]` is 0 sets `tx_status[1]` (character waiting) on the following cycle.
- R3: On a `bit_tick` with a character waiting and the shifter idle, the character moves to the shifter. On the cycle after that tick, `tx_status[1]` is 0, `tx_status[0]` (frame on wire) is 1 and `tx_line` carries the start bit, which is 0. Each later tick advances the line by one bit.
- R4: Data bits leave least significant bit first. `len8`=1 sends bits 7..0 of the byte and `len8`=0 sends bits 6..0. The format inputs are sampled at the tick that loads the shifter.
- R5: `par_sel` chooses the bit that follows the data: 2'b00 sends no parity bit, 2'b01 sends a 0, 2'b10 makes the count of ones across the data and parity bits odd, and 2'b11 makes that count even.
- R6: `stop2`=1 ends the frame with two stop bits and `stop2`=0 with one. Stop bits are 1.
- R7: `tx_irq` is high for exactly one cycle, on the cycle after the tick that ends the last stop bit. It is never high otherwise.
- R8: A write while `tx_status[1]` is 1 is ignored. The waiting character is unchanged, and the ignored byte is never sent.
- R9: If a character is waiting when a frame's last stop bit ends, the same tick loads it. Its start bit follows the previous stop bit with no idle bit between them.
- R10: While `clk_en` or `tx_en` is 0, writes are ignored and the holding register is emptied. A frame in flight is abandoned: on the next cycle `tx_line` is 1 and `tx_status` is 2'b00, and no `tx_irq` pulse is produced for it.
- R11: `tx_line` is 1 whenever `tx_status[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Master clock enable |
| tx_en | input | 1 | Transmit enable |
| par_sel | input | 2 | Parity choice: 00 none, 01 forced zero, 10 odd, 11 even |
| len8 | input | 1 | 1 for eight data bits, 0 for seven |
| stop2 | input | 1 | 1 for two stop bits, 0 for one |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| tx_status | output | 2 | Bit 1 character waiting, bit 0 frame on wire |
| tx_line | output | 1 | Serial output, idles high |
| tx_irq | output | 1 | One-cycle pulse at frame completion |

## Verification
The hardest case to reach is the handoff window, when the holding register is full while a frame is still shifting. That window contains both a write that must be dropped (R8) and the same-tick reload when the final stop bit ends (R9). The bench controls `bit_tick` itself, one pulse per call. This lets it load a first character, write a second and a third into the waiting register between ticks, and then step through both frames bit by bit. Along the way it checks that the second start bit follows the first stop bit directly and that the third byte never appears on the line. The abort case is reached by dropping each enable between two ticks in the middle of a frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
   typedef enum logic [1:0] {
      PAR_NONE = 2'b00,
      PAR_ZERO = 2'b01,
      PAR_ODD  = 2'b10,
      PAR_EVEN = 2'b11
   } par_mode_e;

   localparam int unsigned START_BITS = 1;
   localparam int unsigned MAX_STOP   = 2;
   localparam int unsigned MAX_PAR    = 1;
endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         data <= '0;
      end else if (!active) begin
         full <= 1'b0;
      end else if (take) begin
         full <= 1'b0;
      end else if (wr_en && !full) begin
         full <= 1'b1;
         data <= wr_data;
      end
   end
endmodule

// File: rtl/tx_frame_build.sv
module tx_frame_build
   import uart_tx_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned FRAME_W = DATA_W + 4,
   parameter int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic [DATA_W-1:0]  data,
   input  logic               len_full,
   input  logic [1:0]         par_sel,
   input  logic               stop2,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   frame_len
);
   localparam int unsigned SHORT_W = DATA_W - 1;

   logic [DATA_W-1:0] masked;
   logic              par_bit;
   logic              par_on;
   logic [CNT_W-1:0]  n_data;

   // Mask off the top data bit when the short character length is chosen.
   genvar gi;
   generate
      for (gi = 0; gi < DATA_W; gi++) begin : g_mask
         if (gi < SHORT_W) begin : g_keep
            assign masked[gi] = data[gi];
         end else begin : g_top
            assign masked[gi] = data[gi] & len_full;
         end
      end
   endgenerate

   always_comb begin
      n_data  = len_full ? CNT_W'(DATA_W) : CNT_W'(SHORT_W);
      par_on  = (par_mode_e'(par_sel) != PAR_NONE);
      unique case (par_mode_e'(par_sel))
         PAR_ODD:  par_bit = ~(^masked);
         PAR_EVEN: par_bit = ^masked;
         default:  par_bit = 1'b0;
      endcase

      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (CNT_W'(i) < n_data) frame[i+1] = masked[i];
      end
      if (par_on) frame[n_data + CNT_W'(1)] = par_bit;

      frame_len = CNT_W'(START_BITS) + n_data + CNT_W'(par_on)
                + CNT_W'(1) + CNT_W'(stop2);
   end
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter #(
   parameter int unsigned FRAME_W = 12,
   parameter int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  logic               bit_tick,
   input  logic               buf_full,
   input  logic [FRAME_W-1:0] frame,
   input  logic [CNT_W-1:0]   frame_len,
   output logic               take,
   output logic               busy,
   output logic               line,
   output logic               done_pulse
);
   logic [FRAME_W-1:0] sreg;
   logic [CNT_W-1:0]   remain;
   logic               last_bit;

   assign last_bit = busy && (remain == CNT_W'(1));
   assign take     = active && bit_tick && buf_full && (!busy || last_bit);
   assign line     = busy ? sreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg       <= '1;
         remain     <= '0;
         busy       <= 1'b0;
         done_pulse <= 1'b0;
      end else begin
         done_pulse <= 1'b0;
         if (!active) begin
            sreg   <= '1;
            remain <= '0;
            busy   <= 1'b0;
         end else if (bit_tick) begin
            if (take) begin
               sreg       <= frame;
               remain     <= frame_len;
               busy       <= 1'b1;
               done_pulse <= last_bit;
            end else if (last_bit) begin
               sreg       <= '1;
               remain     <= '0;
               busy       <= 1'b0;
               done_pulse <= 1'b1;
            end else if (busy) begin
               sreg   <= {1'b1, sreg[FRAME_W-1:1]};
               remain <= remain - CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
   import uart_tx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              tx_en,
   input  logic [1:0]        par_sel,
   input  logic              len8,
   input  logic              stop2,
   input  logic              bit_tick,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [1:0]        tx_status,
   output logic              tx_line,
   output logic              tx_irq
);
   localparam int unsigned FRAME_W = START_BITS + DATA_W + MAX_PAR + MAX_STOP;
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

   generate
      if (DATA_W < 2 || DATA_W > 16) begin : g_bad_width
         $error("dbuf_uart_tx: DATA_W must lie in 2..16");
      end
   endgenerate

   logic               active;
   logic               take;
   logic               buf_full;
   logic [DATA_W-1:0]  buf_data;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   frame_len;
   logic               busy;

   assign active = clk_en & tx_en;

   tx_hold_buf #(.DATA_W(DATA_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .active(active), .wr_en(wr_en),
      .wr_data(wr_data), .take(take), .full(buf_full), .data(buf_data)
   );

   tx_frame_build #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_build (
      .data(buf_data), .len_full(len8), .par_sel(par_sel), .stop2(stop2),
      .frame(frame), .frame_len(frame_len)
   );

   tx_frame_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .active(active), .bit_tick(bit_tick),
      .buf_full(buf_full), .frame(frame), .frame_len(frame_len),
      .take(take), .busy(busy), .line(tx_line), .done_pulse(tx_irq)
   );

   assign tx_status = {buf_full, busy};
endmodule

// File: rtl/dbuf_uart_tx_chk.sv
module dbuf_uart_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       clk_en,
   input logic       tx_en,
   input logic       bit_tick,
   input logic       wr_en,
   input logic [1:0] tx_status,
   input logic       tx_line,
   input logic       tx_irq
);
   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_status[0] |-> tx_line);                                    // R11
   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_status[0]) |-> !tx_line);                             // R3
   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |=> !tx_irq);                                           // R7
   AST_IRQ_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> $past(tx_status[0]) && $past(bit_tick));            // R7
   AST_DISABLED_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      !(clk_en && tx_en) |=> (tx_status == 2'b00) && !tx_irq);       // R10
   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_status[1] && clk_en && tx_en && !bit_tick) |=> tx_status[1]); // R8
   AST_WRITE_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && clk_en && tx_en && !tx_status[1]) |=> tx_status[1]); // R2
endmodule

bind dbuf_uart_tx dbuf_uart_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .tx_en(tx_en),
   .bit_tick(bit_tick), .wr_en(wr_en), .tx_status(tx_status),
   .tx_line(tx_line), .tx_irq(tx_irq)
);

// File: tb/sim_dbuf_uart_tx.sv
`timescale 1ns/1ps
module sim_dbuf_uart_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clk_en = 1'b1, tx_en = 1'b1;
   logic [1:0] par_sel = 2'b00;
   logic       len8 = 1'b1, stop2 = 1'b0;
   logic       bit_tick = 1'b0, wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [1:0] tx_status;
   logic       tx_line, tx_irq;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   dbuf_uart_tx u0 (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .tx_en(tx_en),
      .par_sel(par_sel), .len8(len8), .stop2(stop2), .bit_tick(bit_tick),
      .wr_en(wr_en), .wr_data(wr_data), .tx_status(tx_status),
      .tx_line(tx_line), .tx_irq(tx_irq)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_len(input logic l8, input logic [1:0] p, input logic s2);
      return 1 + (l8 ? 8 : 7) + (p != 2'b00 ? 1 : 0) + 1 + (s2 ? 1 : 0);
   endfunction

   function automatic logic exp_bit(input logic [7:0] d, input logic l8,
                                    input logic [1:0] p, input int idx);
      int nd = l8 ? 8 : 7;
      int ones = 0;
      for (int i = 0; i < nd; i++) ones += d[i];
      if (idx == 0) return 1'b0;
      if (idx <= nd) return d[idx-1];
      if (idx == nd + 1 && p != 2'b00) begin
         if (p == 2'b01) return 1'b0;
         if (p == 2'b10) return (ones % 2 == 0);
         return (ones % 2 == 1);
      end
      return 1'b1;
   endfunction

   task automatic tick();
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
   endtask

   task automatic write_byte(input logic [7:0] d);
      @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
      @(negedge clk) wr_en = 1'b0;
   endtask

   task automatic set_fmt(input logic l8, input logic [1:0] p, input logic s2);
      @(negedge clk) begin len8 = l8; par_sel = p; stop2 = s2; end
   endtask

   // One frame, stepped bit by bit (R2, R3, R4, R5, R6, R7, R11)
   task automatic run_frame(input logic [7:0] d, input logic l8,
                            input logic [1:0] p, input logic s2, input string req);
      int n = exp_len(l8, p, s2);
      set_fmt(l8, p, s2);
      write_byte(d);
      check("R2 waiting flag", tx_status, 2'b10);
      for (int k = 0; k < n; k++) begin
         tick();
         check(req, tx_line, exp_bit(d, l8, p, k));
         check("R3 shifting flag", tx_status, 2'b01);
         check("R7 no early irq", tx_irq, 0);
      end
      tick();
      check("R7 irq at end", tx_irq, 1);
      check("R11 idle line", tx_line, 1);
      check("R3 idle status", tx_status, 2'b00);
      @(negedge clk);
      check("R7 irq one cycle", tx_irq, 0);
   endtask

   // Handoff: second char waits, third write ignored (R8, R9)
   task automatic run_back_to_back();
      logic [7:0] a = 8'h3C, b = 8'hC5;
      int n = exp_len(1'b1, 2'b11, 1'b0);
      set_fmt(1'b1, 2'b11, 1'b0);
      write_byte(a);
      tick();
      check("R3 first start", tx_line, 0);
      write_byte(b);
      check("R2 second waiting", tx_status, 2'b11);
      write_byte(8'h00);
      check("R8 full ignores write", tx_status, 2'b11);
      for (int k = 1; k < n; k++) begin
         tick();
         check("R9 first frame", tx_line, exp_bit(a, 1'b1, 2'b11, k));
      end
      tick();
      check("R9 second start no gap", tx_line, 0);
      check("R9 status after reload", tx_status, 2'b01);
      check("R7 irq on first end", tx_irq, 1);
      for (int k = 1; k < n; k++) begin
         tick();
         check("R8 second frame is b", tx_line, exp_bit(b, 1'b1, 2'b11, k));
      end
      tick();
      check("R8 idle after b", tx_status, 2'b00);
      for (int k = 0; k < 4; k++) begin
         tick();
         check("R8 ignored byte not sent", tx_line, 1);
      end
   endtask

   // Abort on each enable (R10)
   task automatic run_abort(input bit use_master);
      set_fmt(1'b1, 2'b00, 1'b0);
      write_byte(8'h00);
      tick();
      tick();
      check("R10 mid-frame low", tx_line, 0);
      @(negedge clk) if (use_master) clk_en = 1'b0; else tx_en = 1'b0;
      @(negedge clk);
      check("R10 line high on abort", tx_line, 1);
      check("R10 status cleared", tx_status, 2'b00);
      check("R10 no irq", tx_irq, 0);
      write_byte(8'h55);
      check("R10 write ignored while off", tx_status, 2'b00);
      @(negedge clk) begin clk_en = 1'b1; tx_en = 1'b1; end
      for (int k = 0; k < 3; k++) begin
         tick();
         check("R10 nothing sent after enable", tx_line, 1);
         check("R10 no irq after abort", tx_irq, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset line", tx_line, 1);
      check("R1 reset status", tx_status, 2'b00);
      check("R1 reset irq", tx_irq, 0);
      @(negedge clk) rst_n = 1'b1;
      run_frame(8'hA5, 1'b1, 2'b00, 1'b0, "R4 8N1");
      run_frame(8'hD3, 1'b0, 2'b11, 1'b0, "R5 7E1");
      run_frame(8'h81, 1'b1, 2'b10, 1'b1, "R6 8O2");
      run_frame(8'hFF, 1'b1, 2'b01, 1'b0, "R5 8Z1");
      run_frame(8'h80, 1'b0, 2'b00, 1'b1, "R4 7N2 top bit dropped");
      run_back_to_back();
      run_abort(1'b0);
      run_abort(1'b1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule